// File: doc/BRIEF.md
# Auxiliary UART Register Front End

This block is the register-side core of a small auxiliary UART. A processor reaches it over a simple 32-bit word-access register bus, with an address, a read strobe, a write strobe and write data. Read data is combinational and valid while the read strobe is high. Any side effect of a read, such as popping the receive queue, takes effect at the clock edge that ends the access.

Received bytes come in on a valid/ready byte stream and are stored in a circular receive queue. Software drains the queue through the data register.

Transmitted bytes are not buffered. A write to the data register puts the byte on the transmit stream for exactly one cycle. Because of this, the transmit side always reports itself idle and empty, and an enabled transmit interrupt is always pending.

A single level-sensitive interrupt output combines receive-data-available and transmit-ready, each gated by its own enable bit. Baud generation, line and modem control, the scratch register and serial-peripheral functions are not part of this block. Their offsets read as zero.

Top module: `aux_uart_regs`

## Requirements
- R1: After synchronous reset the receive queue is empty (data register reads 0x00), `rx_ready` is high, the interrupt enable bits are 0 and `irq` is low.
- R2: Writing offset 0x44 stores only write-data bits 1:0 (bit 0 = receive enable, bit 1 = transmit enable). A read of 0x44 returns 0xC0 ORed with those two bits.
- R3: `irq` is high exactly when (receive enable is set and the queue holds at least one byte) or the transmit enable is set.
- R4: A read of offset 0x48 returns 0xC0, ORed with 0x04 when the queue is non-empty or 0x02 when it is empty, and further ORed with 0x01 when `irq` is low.
- R5: A write to offset 0x48 with write-data bit 1 set empties the queue without moving the read pointer, and `rx_ready` is low during that write. A write with bit 1 clear changes nothing.
- R6: A read of offset 0x40 on a non-empty queue returns the oldest byte, advances the read pointer modulo the depth and lowers the count by one, so bytes leave in arrival order across wraparound.
- R7: A read of offset 0x40 on an empty queue returns the entry at the read pointer and leaves the count and the pointer unchanged.
- R8: `rx_ready` is low while the queue holds DEPTH bytes, and a byte offered then is not stored.
- R9: A read of offset 0x54 returns 0x60, with bit 0 set when the queue is non-empty.
- R10: A read of offset 0x64 returns 0x30E, with bit 0 set when the queue is non-empty and the fill count in bits 23:16.
- R11: Offset 0x04 reads 0x1, offset 0x60 reads 0x3, and offset 0x00 reads 1 when `irq` is high and 0 otherwise.
- R12: A write to offset 0x40 drives `tx_valid` high for exactly the following cycle, with `tx_data` equal to write-data bits 7:0.
- R13: Reads of offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and any unlisted offset return 0. Writes to those offsets and to 0x00, 0x04, 0x54, 0x60 and 0x64 change no state.
- R14: A byte accepted in the same cycle as a data-register read of a non-empty queue is stored behind the remaining bytes, and the count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_rd | input | 1 | Read strobe; read side effects at the ending edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid while `bus_rd` is high, else zero |
| rx_data | input | DATA_W | Incoming received byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Queue can accept a byte this cycle |
| tx_data | output | DATA_W | Outgoing byte |
| tx_valid | output | 1 | One-cycle pulse marking an outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with DEPTH set to 4 instead of the default 8. A shallow queue lets a handful of pushes reach the full condition, the back-pressure on `rx_ready` and read-pointer wraparound within a few dozen cycles. The stale-entry read after a flush and the simultaneous push-and-pop case are also reached with the pointer at an interior, non-zero slot. All other widths keep their defaults, so the register encodings are checked at their real bit positions.

// File: rtl/aux_uart_pkg.sv
package aux_uart_pkg;

    // register byte offsets (decoded by software, kept fixed)
    localparam logic [7:0] OFF_SUMMARY = 8'h00;
    localparam logic [7:0] OFF_ENABLES = 8'h04;
    localparam logic [7:0] OFF_DATA    = 8'h40;
    localparam logic [7:0] OFF_IEN     = 8'h44;
    localparam logic [7:0] OFF_IID     = 8'h48;
    localparam logic [7:0] OFF_LSTAT   = 8'h54;
    localparam logic [7:0] OFF_XCTRL   = 8'h60;
    localparam logic [7:0] OFF_XSTAT   = 8'h64;

    // fixed read patterns
    localparam logic [7:0]  IEN_FIXED   = 8'hC0;
    localparam logic [7:0]  IID_FIXED   = 8'hC0;
    localparam logic [7:0]  IID_RXDATA  = 8'h04;
    localparam logic [7:0]  IID_TXREADY = 8'h02;
    localparam logic [7:0]  IID_NOPEND  = 8'h01;
    localparam logic [7:0]  LSTAT_FIXED = 8'h60;
    localparam logic [7:0]  XCTRL_VALUE = 8'h03;
    localparam logic [31:0] XSTAT_FIXED = 32'h0000_030E;
    localparam int          LEVEL_LSB   = 16;
    localparam int          LEVEL_W     = 8;

    typedef enum logic [3:0] {
        SEL_SUMMARY,
        SEL_ENABLES,
        SEL_DATA,
        SEL_IEN,
        SEL_IID,
        SEL_LSTAT,
        SEL_XCTRL,
        SEL_XSTAT,
        SEL_NONE
    } reg_sel_e;

    // receive queue state as seen by the read side
    typedef struct packed {
        logic [7:0]         head;
        logic [LEVEL_W-1:0] level;
        logic               nonempty;
    } rxq_view_t;

    // interrupt enable bits
    typedef struct packed {
        logic tx_en;
        logic rx_en;
    } ien_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        case (off)
            OFF_SUMMARY: return SEL_SUMMARY;
            OFF_ENABLES: return SEL_ENABLES;
            OFF_DATA:    return SEL_DATA;
            OFF_IEN:     return SEL_IEN;
            OFF_IID:     return SEL_IID;
            OFF_LSTAT:   return SEL_LSTAT;
            OFF_XCTRL:   return SEL_XCTRL;
            OFF_XSTAT:   return SEL_XSTAT;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] iid_value(input logic nonempty, input logic pending);
        logic [7:0] v;
        v = IID_FIXED | (nonempty ? IID_RXDATA : IID_TXREADY);
        if (!pending) v = v | IID_NOPEND;
        return v;
    endfunction

endpackage

// File: rtl/aux_addr_decode.sv
module aux_addr_decode
    import aux_uart_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

    logic upper_clear;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign upper_clear = (addr[ADDR_W-1:8] == HI_W'(0));
        end else begin : g_narrow
            assign upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        if (upper_clear) sel = decode_offset(addr[7:0]);
        else             sel = SEL_NONE;
    end
endmodule

// File: rtl/aux_rx_fifo.sv
module aux_rx_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              full
);
    localparam int SUM_W = CNT_W + 1;

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [SUM_W-1:0]  slot_sum;
    logic [PTR_W-1:0]  wr_slot;
    logic [PTR_W-1:0]  ptr_next;

    // write slot = (read pointer + count) modulo depth
    always_comb begin
        slot_sum = SUM_W'(rd_ptr) + SUM_W'(count);
        if (slot_sum >= SUM_W'(DEPTH)) wr_slot = PTR_W'(slot_sum - SUM_W'(DEPTH));
        else                           wr_slot = PTR_W'(slot_sum);
        ptr_next = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)                                  slot_q[i] <= '0;
                else if (push && wr_slot == PTR_W'(i))    slot_q[i] <= push_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= ptr_next;
            if (flush)            count <= '0;
            else if (push && !pop) count <= count + CNT_W'(1);
            else if (!push && pop) count <= count - CNT_W'(1);
        end
    end

    assign head_data = slot_q[rd_ptr];
    assign full      = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/aux_irq_ctrl.sv
module aux_irq_ctrl
    import aux_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ien_wr,
    input  logic [1:0] ien_wdata,
    input  logic       rx_nonempty,
    output ien_t       ien,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst)         ien <= '0;
        else if (ien_wr) ien <= ien_t'(ien_wdata);
    end

    // transmit side drains at once, so an enabled transmit interrupt is always pending
    assign irq = (ien.rx_en && rx_nonempty) || ien.tx_en;
endmodule

// File: rtl/aux_read_mux.sv
module aux_read_mux
    import aux_uart_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             rd,
    input  reg_sel_e         sel,
    input  rxq_view_t        rxq,
    input  ien_t             ien,
    input  logic             irq,
    output logic [BUS_W-1:0] rdata
);
    logic [31:0] word;

    always_comb begin
        word = '0;
        case (sel)
            SEL_SUMMARY: word = {31'd0, irq};
            SEL_ENABLES: word = 32'd1;
            SEL_DATA:    word = {24'd0, rxq.head};
            SEL_IEN:     word = {24'd0, IEN_FIXED | {6'd0, ien}};
            SEL_IID:     word = {24'd0, iid_value(rxq.nonempty, irq)};
            SEL_LSTAT:   word = {24'd0, LSTAT_FIXED | {7'd0, rxq.nonempty}};
            SEL_XCTRL:   word = {24'd0, XCTRL_VALUE};
            SEL_XSTAT:   word = XSTAT_FIXED | {31'd0, rxq.nonempty}
                                | (32'(rxq.level) << LEVEL_LSB);
            default:     word = '0;
        endcase
        rdata = rd ? BUS_W'(word) : '0;
    end
endmodule

// File: rtl/aux_uart_regs.sv
module aux_uart_regs
    import aux_uart_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              irq
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    reg_sel_e          sel;
    logic              wr_data, rd_data, wr_ien, flush;
    logic              push, pop, full;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  occ_count;
    logic [PTR_W-1:0]  rd_ptr_q;
    ien_t              ien_q;
    rxq_view_t         rxq;
    logic              unused_wbits;

    aux_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_data = bus_wr && (sel == SEL_DATA);
    assign rd_data = bus_rd && (sel == SEL_DATA);
    assign wr_ien  = bus_wr && (sel == SEL_IEN);
    assign flush   = bus_wr && (sel == SEL_IID) && bus_wdata[1];

    assign rx_ready = !full && !flush;
    assign push     = rx_valid && rx_ready;
    assign pop      = rd_data && (occ_count != '0);

    aux_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .flush     (flush),
        .head_data (head_data),
        .count     (occ_count),
        .rd_ptr    (rd_ptr_q),
        .full      (full)
    );

    aux_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .ien_wr      (wr_ien),
        .ien_wdata   (bus_wdata[1:0]),
        .rx_nonempty (occ_count != '0),
        .ien         (ien_q),
        .irq         (irq)
    );

    always_comb begin
        rxq.head     = 8'(head_data);
        rxq.level    = LEVEL_W'(occ_count);
        rxq.nonempty = (occ_count != '0);
    end

    aux_read_mux #(.BUS_W(BUS_W)) u_rmux (
        .rd    (bus_rd),
        .sel   (sel),
        .rxq   (rxq),
        .ien   (ien_q),
        .irq   (irq),
        .rdata (bus_rdata)
    );

    // transmit: one-cycle pulse after a data-register write
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= wr_data;
            if (wr_data) tx_data <= bus_wdata[DATA_W-1:0];
        end
    end

    assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/aux_uart_regs_chk.sv
module aux_uart_regs_chk
    import aux_uart_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [1:0]        ien
);
    logic hit_data, hit_ien, hit_iid, accepted;
    assign hit_data = (bus_addr == ADDR_W'(OFF_DATA));
    assign hit_ien  = (bus_addr == ADDR_W'(OFF_IEN));
    assign hit_iid  = (bus_addr == ADDR_W'(OFF_IID));
    assign accepted = rx_valid && rx_ready;

    p_ien_store_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_ien) |=> (ien == $past(bus_wdata[1:0])));

    p_irq_tx_r3: assert property (@(posedge clk) disable iff (rst)
        ien[1] |-> irq);

    p_irq_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!ien[1] && (!ien[0] || count == '0)) |-> !irq);

    p_flush_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_iid && bus_wdata[1]) |=> (count == '0));

    p_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit_data && count != '0 && !accepted) |=>
        (count == $past(count) - CNT_W'(1)));

    p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit_data && count == '0 && !accepted) |=>
        (count == '0 && $stable(rd_ptr)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !rx_ready);

    p_tx_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_data) |=> (tx_valid && tx_data == $past(bus_wdata[DATA_W-1:0])));

    p_tx_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && hit_data) |=> !tx_valid);

    p_pushpop_r14: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit_data && count != '0 && accepted) |=> $stable(count));
endmodule

bind aux_uart_regs aux_uart_regs_chk #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .irq       (irq),
    .count     (occ_count),
    .rd_ptr    (rd_ptr_q),
    .ien       (ien_q)
);

// File: tb/aux_uart_regs_bench.sv
module aux_uart_regs_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    aux_uart_regs #(.DEPTH(DEPTH)) u_aux_uart_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
        .tx_valid(tx_valid), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, output logic took);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        #1 took = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic expect_push(input string req, input logic [7:0] b, input logic exp);
        logic took;
        push(b, took);
        check(req, {31'd0, took}, {31'd0, exp});
    endtask

    function automatic logic [31:0] xstat(input int n);
        return 32'h30E | ((n != 0) ? 32'd1 : 32'd0) | (32'(n) << 16);
    endfunction

    task automatic t_reset;
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 rx_ready", {31'd0, rx_ready}, 1);
        expect_rd("R1 data", 8'h40, 32'h00);
        expect_rd("R1 ien", 8'h44, 32'hC0);
        expect_rd("R9 lstat empty", 8'h54, 32'h60);
        expect_rd("R10 xstat empty", 8'h64, xstat(0));
    endtask

    task automatic t_const;
        expect_rd("R11 enables", 8'h04, 32'h1);
        expect_rd("R11 xctrl", 8'h60, 32'h3);
        expect_rd("R11 summary idle", 8'h00, 32'h0);
    endtask

    task automatic t_unknown;
        wr(8'h4C, 32'hFF); wr(8'h50, 32'hFF); wr(8'h5C, 32'hFF); wr(8'h68, 32'hFF);
        wr(8'h60, 32'hFF); wr(8'h08, 32'hFF); wr(8'h54, 32'hFF); wr(8'h00, 32'hFF);
        expect_rd("R13 lctrl", 8'h4C, 0);
        expect_rd("R13 mctrl", 8'h50, 0);
        expect_rd("R13 mstat", 8'h58, 0);
        expect_rd("R13 scratch", 8'h5C, 0);
        expect_rd("R13 baud", 8'h68, 0);
        expect_rd("R13 hole", 8'h08, 0);
        expect_rd("R13 xctrl kept", 8'h60, 32'h3);
        expect_rd("R13 ien kept", 8'h44, 32'hC0);
        expect_rd("R13 queue kept", 8'h54, 32'h60);
        check("R13 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_ien;
        wr(8'h44, 32'hFF);
        expect_rd("R2 ien masked", 8'h44, 32'hC3);
        check("R3 irq tx enable", {31'd0, irq}, 1);
        expect_rd("R11 summary set", 8'h00, 32'h1);
        wr(8'h44, 32'hFC);
        expect_rd("R2 ien cleared", 8'h44, 32'hC0);
        check("R3 irq off", {31'd0, irq}, 0);
    endtask

    task automatic t_order;
        expect_push("R6 push1", 8'hA1, 1);
        expect_push("R6 push2", 8'hA2, 1);
        expect_push("R6 push3", 8'hA3, 1);
        expect_rd("R9 lstat data", 8'h54, 32'h61);
        expect_rd("R10 xstat 3", 8'h64, xstat(3));
        expect_rd("R6 pop1", 8'h40, 32'hA1);
        expect_rd("R6 pop2", 8'h40, 32'hA2);
        expect_rd("R6 pop3", 8'h40, 32'hA3);
        expect_rd("R6 drained", 8'h54, 32'h60);
    endtask

    task automatic t_full_wrap;
        for (int i = 0; i < DEPTH; i++) expect_push("R8 fill", 8'hC0 + 8'(i), 1);
        check("R8 ready low", {31'd0, rx_ready}, 0);
        expect_push("R8 refused", 8'hEE, 0);
        expect_rd("R10 xstat full", 8'h64, xstat(DEPTH));
        expect_rd("R6 wrap pop0", 8'h40, 32'hC0);
        expect_rd("R6 wrap pop1", 8'h40, 32'hC1);
        expect_push("R6 wrap push4", 8'hC4, 1);
        expect_push("R6 wrap push5", 8'hC5, 1);
        for (int i = 2; i < 6; i++) expect_rd("R6 wrap order", 8'h40, 32'hC0 + 32'(i));
        expect_rd("R8 empty again", 8'h54, 32'h60);
    endtask

    task automatic t_flush_stale;
        expect_push("R5 push", 8'hD1, 1);
        expect_push("R5 push", 8'hD2, 1);
        wr(8'h48, 32'h01);
        expect_rd("R5 no flush", 8'h64, xstat(2));
        @(negedge clk);
        bus_addr = 8'h48; bus_wdata = 32'h02; bus_wr = 1'b1;
        #1 check("R5 ready low in flush", {31'd0, rx_ready}, 0);
        @(negedge clk);
        bus_wr = 1'b0;
        expect_rd("R5 flushed", 8'h54, 32'h60);
        check("R5 ready back", {31'd0, rx_ready}, 1);
        expect_rd("R7 stale", 8'h40, 32'hD1);
        expect_rd("R7 count kept", 8'h64, xstat(0));
        expect_rd("R7 stale again", 8'h40, 32'hD1);
    endtask

    task automatic t_irq;
        wr(8'h44, 32'h1);
        check("R3 rx empty", {31'd0, irq}, 0);
        expect_rd("R4 none", 8'h48, 32'hC3);
        expect_push("R3 push", 8'hE1, 1);
        check("R3 rx data", {31'd0, irq}, 1);
        expect_rd("R4 rx pend", 8'h48, 32'hC4);
        wr(8'h44, 32'h0);
        check("R3 rx masked", {31'd0, irq}, 0);
        expect_rd("R4 rx masked", 8'h48, 32'hC5);
        wr(8'h44, 32'h2);
        expect_rd("R4 tx with data", 8'h48, 32'hC4);
        expect_rd("R6 drain", 8'h40, 32'hE1);
        expect_rd("R4 tx pend", 8'h48, 32'hC2);
        check("R3 tx pend", {31'd0, irq}, 1);
        wr(8'h44, 32'h0);
    endtask

    task automatic t_tx;
        wr(8'h40, 32'h1A5);
        check("R12 valid", {31'd0, tx_valid}, 1);
        check("R12 data", {24'd0, tx_data}, 32'hA5);
        @(negedge clk);
        check("R12 one cycle", {31'd0, tx_valid}, 0);
        expect_rd("R12 no rx effect", 8'h54, 32'h60);
    endtask

    task automatic t_simul;
        logic [31:0] d;
        logic        took;
        expect_push("R14 prime", 8'hB0, 1);
        @(negedge clk);
        bus_addr = 8'h40; bus_rd = 1'b1; rx_data = 8'hB1; rx_valid = 1'b1;
        #1 d = bus_rdata; took = rx_ready;
        @(negedge clk);
        bus_rd = 1'b0; rx_valid = 1'b0;
        check("R14 head", d, 32'hB0);
        check("R14 accepted", {31'd0, took}, 1);
        expect_rd("R14 count", 8'h64, xstat(1));
        expect_rd("R14 new byte", 8'h40, 32'hB1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_const();
        t_unknown();
        t_ien();
        t_order();
        t_full_wrap();
        t_flush_stale();
        t_irq();
        t_tx();
        t_simul();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule